// File: doc/BRIEF.md
# DRAM Multi-Purpose Register Read Responder

This block is the device-side model of the calibration register that a DDR3-style memory exposes for read training. A controller issues a mode-register-set command to mode register 3 to switch the device into a register-read mode and to pick a data location. While that mode is on, every READ returns a fixed calibration pattern instead of array contents. The pattern appears after the configured read latency as a burst of 8 or 4 beats on a 16-bit data bus, one beat per clock, with a valid flag on each beat.

The burst length comes from a mode register 0 style setting: fixed 8, fixed 4 (burst chop), or chosen per READ from address bit 12. For a burst-chop read, column bit 2 selects the lower or upper half of the 8-beat pattern. A READ that arrives while the DLL is not locked, that has illegal low column bits, or that comes while a burst is still pending is rejected. A rejected READ sets a sticky error flag and drives no beats. The block uses no memory array, and it models no DLL, termination or electrical timing.

Top module: `mpr_read_responder`

## Requirements
- R1: An MRS command (`cmd_op`=1) with `cmd_bank`=3 sets `mpr_mode` to `cmd_addr[2]` from the next cycle on. An MRS to any other bank leaves `mpr_mode` unchanged. After reset `mpr_mode`=0, `mpr_err`=0 and `dq_valid`=0.
- R2: The same MR3 write stores `cmd_addr[1:0]` as the location. Location 00 returns, at burst position p (0..7), the bit 1 when p is odd and 0 when p is even. Locations 01, 10 and 11 return all-zero beats with `dq_valid` still asserted.
- R3: An 8-beat read needs column bits `cmd_addr[2:0]`=000 and returns positions 0,1,2,...,7 in order.
- R4: A 4-beat read needs `cmd_addr[1:0]`=00. `cmd_addr[2]`=0 returns positions 0..3 and `cmd_addr[2]`=1 returns positions 4..7.
- R5: `burst_cfg` 00 gives 8 beats and 10 gives 4 beats. With 01, `cmd_addr[12]`=1 gives 8 beats and 0 gives 4 beats. 11 is treated as 8 beats.
- R6: During a beat, `dq[0]` and `dq[8]` carry the pattern bit. `dq[7:1]` and `dq[15:9]` copy it when `lane_copy`=1 and are 0 when `lane_copy`=0. Outside beats `dq` is all zero.
- R7: `cmd_bank`, `cmd_addr[10]`, `cmd_addr[11]`, `cmd_addr[9:3]` and `cmd_addr[14:13]` have no effect on the data of a register read.
- R8: A READ sampled in cycle c drives its first beat in cycle c+`read_lat` (a `read_lat` of 0 acts as 1). `dq_valid` then stays high for exactly 8 or 4 consecutive cycles.
- R9: A READ in register mode with `dll_locked`=0 sets `mpr_err` and produces no beats.
- R10: A READ in register mode whose low column bits break R3 or R4 sets `mpr_err` and produces no beats.
- R11: A READ that arrives while a burst is pending is rejected and sets `mpr_err`. The pending burst completes unchanged.
- R12: A READ while `mpr_mode`=0 produces no beats and does not set `mpr_err`. `mpr_err` clears only on reset.
- R13: An MRS to MR3 during a burst changes `mpr_mode` at once. The pending burst completes with the location captured when its READ was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 0 none, 1 MRS, 2 READ, 3 other |
| cmd_bank | input | 3 | Bank address; selects the mode register on MRS |
| cmd_addr | input | 15 | Address bus of the command |
| dll_locked | input | 1 | DLL lock indication |
| burst_cfg | input | 2 | Mode register 0 burst setting |
| read_lat | input | 5 | Read latency in clocks |
| lane_copy | input | 1 | 1: upper bits copy the pattern bit; 0: drive 0 |
| dq | output | 16 | Read data beat |
| dq_valid | output | 1 | Beat valid |
| mpr_err | output | 1 | Sticky error for rejected reads |
| mpr_mode | output | 1 | Register-read mode active |

## Verification
Two functions can meet in the same cycle: the beat sequencer drains a pending burst while the command decoder takes a new command. The bench sends a second READ and, in a separate test, an MR3 exit in the middle of a running burst. In each case it compares every remaining beat against the pattern the first READ called for. A rejected READ must raise only the error flag. An exit must flip the mode flag without cutting the burst short or changing its data.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_MRS   = 2'd1,
    OP_READ  = 2'd2,
    OP_OTHER = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    BURST_FIX8 = 2'd0,
    BURST_OTF  = 2'd1,
    BURST_FIX4 = 2'd2,
    BURST_RSV  = 2'd3
  } burst_e;

  // bit p = value at burst position p
  localparam logic [7:0] CAL_PATTERN = 8'b1010_1010;

  function automatic logic pick_chop(input logic [1:0] mode, input logic a12);
    case (burst_e'(mode))
      BURST_FIX4: return 1'b1;
      BURST_OTF:  return !a12;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] burst_beats(input logic chop);
    return chop ? 4'd4 : 4'd8;
  endfunction

  function automatic logic cols_legal(input logic chop, input logic [2:0] col);
    return chop ? (col[1:0] == 2'b00) : (col == 3'b000);
  endfunction

  function automatic logic [2:0] first_pos(input logic chop, input logic [2:0] col);
    return chop ? {col[2], 2'b00} : 3'd0;
  endfunction

  function automatic logic loc_bit(input logic [1:0] loc, input logic [2:0] pos);
    return (loc == 2'b00) ? CAL_PATTERN[pos] : 1'b0;
  endfunction
endpackage

// File: rtl/mpr_mode_reg.sv
module mpr_mode_reg #(
  parameter int BANK_W = 3,
  parameter int MR_SEL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op,
  input  logic [BANK_W-1:0] bank,
  input  logic [2:0]        addr_low,
  output logic              mpr_on,
  output logic [1:0]        mpr_loc
);
  import mpr_pkg::*;

  logic mr3_write;
  assign mr3_write = (op_e'(op) == OP_MRS) && (bank == BANK_W'(MR_SEL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mpr_on  <= 1'b0;
      mpr_loc <= 2'b00;
    end else if (mr3_write) begin
      mpr_on  <= addr_low[2];
      mpr_loc <= addr_low[1:0];
    end
  end

  p_mode_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mr3_write |=> (mpr_on == $past(addr_low[2])));
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mr3_write |=> ($stable(mpr_on) && $stable(mpr_loc)));
endmodule

// File: rtl/mpr_read_ctrl.sv
module mpr_read_ctrl #(
  parameter int LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic             a12,
  input  logic [2:0]       col_low,
  input  logic [1:0]       burst_mode,
  input  logic             dll_locked,
  input  logic [LAT_W-1:0] rd_lat,
  input  logic             mpr_on,
  input  logic [1:0]       mpr_loc,
  output logic             beat_valid,
  output logic [2:0]       beat_pos,
  output logic [1:0]       beat_loc,
  output logic             err_sticky
);
  import mpr_pkg::*;
  localparam int TW = LAT_W + 2;

  logic             busy;
  logic [TW-1:0]    tick;
  logic [LAT_W-1:0] lat_q;
  logic [3:0]       len_q;
  logic [2:0]       start_q;
  logic [1:0]       loc_q;

  // named events
  logic rd_cmd, chop, rd_accept, rd_reject, last_beat;
  logic [TW-1:0] lat_x, end_x, offs;
  logic [LAT_W-1:0] lat_eff;

  assign rd_cmd    = (op_e'(op) == OP_READ) && mpr_on;
  assign chop      = pick_chop(burst_mode, a12);
  assign rd_accept = rd_cmd && !busy && dll_locked && cols_legal(chop, col_low);
  assign rd_reject = rd_cmd && !rd_accept;
  assign lat_eff   = (rd_lat == '0) ? LAT_W'(1) : rd_lat;

  assign lat_x      = TW'(lat_q);
  assign end_x      = lat_x + TW'(len_q);
  assign offs       = tick - lat_x;
  assign beat_valid = busy && (tick >= lat_x) && (tick < end_x);
  assign last_beat  = busy && (tick == end_x - TW'(1));
  assign beat_pos   = start_q + offs[2:0];
  assign beat_loc   = loc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tick    <= '0;
      lat_q   <= LAT_W'(1);
      len_q   <= 4'd0;
      start_q <= 3'd0;
      loc_q   <= 2'd0;
    end else if (rd_accept) begin
      busy    <= 1'b1;
      tick    <= TW'(1);
      lat_q   <= lat_eff;
      len_q   <= burst_beats(chop);
      start_q <= first_pos(chop, col_low);
      loc_q   <= mpr_loc;
    end else if (busy) begin
      tick <= tick + TW'(1);
      if (last_beat) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         err_sticky <= 1'b0;
    else if (rd_reject) err_sticky <= 1'b1;
  end

  // run-length monitor for the beat window
  logic [3:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          run_q <= 4'd0;
    else if (beat_valid) run_q <= run_q + 4'd1;
    else                 run_q <= 4'd0;
  end

  p_run_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(beat_valid) |-> (run_q == 4'd4 || run_q == 4'd8));
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  p_reject_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reject && !busy) |=> !busy);
  p_dll_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(dll_locked));
  p_busy_keeps_loc_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_accept) |=> $stable(loc_q));
endmodule

// File: rtl/mpr_beat_drive.sv
module mpr_beat_drive #(
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        beat_valid,
  input  logic [2:0]                  beat_pos,
  input  logic [1:0]                  beat_loc,
  input  logic                        copy_mode,
  output logic [NUM_LANES*LANE_W-1:0] dq
);
  import mpr_pkg::*;
  localparam int DW = NUM_LANES * LANE_W;

  logic beat_bit;
  assign beat_bit = beat_valid & loc_bit(beat_loc, beat_pos);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign dq[g*LANE_W] = beat_bit;
    assign dq[g*LANE_W+1 +: LANE_W-1] = {(LANE_W-1){beat_bit & copy_mode}};
  end

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> (dq == '0));
  p_lanes_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq[0] == dq[LANE_W]);
  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_mode |-> ((dq & ~{NUM_LANES{{(LANE_W-1){1'b0}}, 1'b1}}) == DW'(0)));
endmodule

// File: rtl/mpr_read_responder.sv
module mpr_read_responder #(
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8,
  parameter int ADDR_W    = 15,
  parameter int BANK_W    = 3,
  parameter int LAT_W     = 5,
  parameter int MR_SEL    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  cmd_op,
  input  logic [BANK_W-1:0]           cmd_bank,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic                        dll_locked,
  input  logic [1:0]                  burst_cfg,
  input  logic [LAT_W-1:0]            read_lat,
  input  logic                        lane_copy,
  output logic [NUM_LANES*LANE_W-1:0] dq,
  output logic                        dq_valid,
  output logic                        mpr_err,
  output logic                        mpr_mode
);
  logic       mpr_on;
  logic [1:0] mpr_loc;
  logic [2:0] beat_pos;
  logic [1:0] beat_loc;
  logic       beat_valid;

  mpr_mode_reg #(.BANK_W(BANK_W), .MR_SEL(MR_SEL)) u_mode (
    .clk(clk), .rst_n(rst_n), .op(cmd_op), .bank(cmd_bank),
    .addr_low(cmd_addr[2:0]), .mpr_on(mpr_on), .mpr_loc(mpr_loc)
  );

  mpr_read_ctrl #(.LAT_W(LAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(cmd_op), .a12(cmd_addr[12]),
    .col_low(cmd_addr[2:0]), .burst_mode(burst_cfg), .dll_locked(dll_locked),
    .rd_lat(read_lat), .mpr_on(mpr_on), .mpr_loc(mpr_loc),
    .beat_valid(beat_valid), .beat_pos(beat_pos), .beat_loc(beat_loc),
    .err_sticky(mpr_err)
  );

  mpr_beat_drive #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_pos(beat_pos),
    .beat_loc(beat_loc), .copy_mode(lane_copy), .dq(dq)
  );

  assign dq_valid = beat_valid;
  assign mpr_mode = mpr_on;
endmodule

// File: tb/mpr_read_responder_tb.sv
module mpr_read_responder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_bank;
  logic [14:0] cmd_addr;
  logic        dll_locked;
  logic [1:0]  burst_cfg;
  logic [4:0]  read_lat;
  logic        lane_copy;
  logic [15:0] dq;
  logic        dq_valid, mpr_err, mpr_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpr_read_responder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .dll_locked(dll_locked), .burst_cfg(burst_cfg),
    .read_lat(read_lat), .lane_copy(lane_copy), .dq(dq), .dq_valid(dq_valid),
    .mpr_err(mpr_err), .mpr_mode(mpr_mode)
  );

  typedef struct packed {
    logic [1:0] loc;
    logic [1:0] burst;
    logic       a12;
    logic [2:0] col;
    logic       junk;
    logic       copy;
    logic [4:0] lat;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{2'd0, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd1},
    '{2'd0, 2'd2, 1'b0, 3'd0, 1'b0, 1'b0, 5'd2},
    '{2'd0, 2'd2, 1'b0, 3'd4, 1'b1, 1'b1, 5'd3},
    '{2'd0, 2'd1, 1'b1, 3'd0, 1'b0, 1'b1, 5'd4},
    '{2'd0, 2'd1, 1'b0, 3'd4, 1'b0, 1'b0, 5'd5},
    '{2'd1, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd2},
    '{2'd3, 2'd2, 1'b0, 3'd4, 1'b1, 1'b1, 5'd3},
    '{2'd0, 2'd3, 1'b0, 3'd0, 1'b1, 1'b1, 5'd0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_op = 2'd0; cmd_bank = 3'd0; cmd_addr = 15'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic mrs(input logic [2:0] bank, input logic [14:0] addr);
    @(negedge clk);
    cmd_op = 2'd1; cmd_bank = bank; cmd_addr = addr;
    @(negedge clk);
    cmd_op = 2'd0;
  endtask

  // Expected word at position pos for location loc
  function automatic logic [15:0] exp_word(input logic [1:0] loc, input int pos, input logic copy);
    if (loc != 2'd0 || (pos % 2) == 0) return 16'h0000;
    return copy ? 16'hFFFF : 16'h0101;
  endfunction

  // Issue a READ and compare every cycle of the expected window.
  // inj_j > 0 drives inj_op/bank/addr in that cycle of the window.
  task automatic run_read(input string tag, input logic [14:0] addr, input logic [2:0] bank,
                          input int lat, input int len, input int start, input logic [1:0] loc,
                          input logic copy, input int inj_j, input logic [1:0] inj_op,
                          input logic [2:0] inj_bank, input logic [14:0] inj_addr);
    int elat;
    elat = (lat == 0) ? 1 : lat;
    @(negedge clk);
    cmd_op = 2'd2; cmd_addr = addr; cmd_bank = bank;
    @(negedge clk);
    cmd_op = 2'd0;
    for (int j = 1; j <= elat + len + 1; j++) begin
      bit ev;
      logic [15:0] ew;
      if (j == inj_j) begin
        cmd_op = inj_op; cmd_bank = inj_bank; cmd_addr = inj_addr;
      end else if (j == inj_j + 1) begin
        cmd_op = 2'd0;
      end
      ev = (j >= elat) && (j < elat + len);
      ew = ev ? exp_word(loc, start + j - elat, copy) : 16'h0000;
      check({dq_valid, dq} == {ev, ew}, tag, {15'd0, dq_valid, dq}, {15'd0, ev, ew});
      @(negedge clk);
    end
    cmd_op = 2'd0;
  endtask

  initial begin
    dll_locked = 1'b1; burst_cfg = 2'd0; read_lat = 5'd2; lane_copy = 1'b1;
    do_reset();
    // R1 reset state
    check(!mpr_mode && !mpr_err && !dq_valid && dq == 16'h0, "R1 reset state",
          {13'd0, mpr_mode, mpr_err, dq_valid, dq}, 32'd0);
    // R1 MRS to another bank has no effect
    mrs(3'd2, 15'h0004);
    check(mpr_mode == 1'b0, "R1 non-MR3 write ignored", {31'd0, mpr_mode}, 32'd0);
    // R12 read while mode off: no beats, no error
    run_read("R12 read outside mode", 15'h0000, 3'd0, 2, 0, 0, 2'd0, 1'b1, 0, 2'd0, 3'd0, 15'd0);
    check(mpr_err == 1'b0, "R12 no error outside mode", {31'd0, mpr_err}, 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    foreach (VECS[i]) begin
      vec_t v;
      bit chop;
      logic [14:0] a;
      logic [2:0] b;
      v = VECS[i];
      mrs(3'd3, {12'd0, 1'b1, v.loc});
      check(mpr_mode == 1'b1, "R1 MR3 enter", {31'd0, mpr_mode}, 32'd1);
      burst_cfg = v.burst; lane_copy = v.copy; read_lat = v.lat;
      chop = (v.burst == 2'd2) || (v.burst == 2'd1 && !v.a12);
      a = {2'b00, v.a12, 9'd0, v.col} | (v.junk ? 15'h6FF8 : 15'h0000);
      b = v.junk ? 3'd5 : 3'd0;
      run_read("R2/R3/R4/R5/R6/R7/R8 table", a, b, int'(v.lat), chop ? 4 : 8,
               chop ? (v.col[2] ? 4 : 0) : 0, v.loc, v.copy, 0, 2'd0, 3'd0, 15'd0);
    end
    check(mpr_err == 1'b0, "R7 legal table raised no error", {31'd0, mpr_err}, 32'd0);

    // R13 MR3 exit mid-burst
    mrs(3'd3, 15'h0004);
    burst_cfg = 2'd0; lane_copy = 1'b1; read_lat = 5'd2;
    run_read("R13 burst survives MR3 exit", 15'h0000, 3'd0, 2, 8, 0, 2'd0, 1'b1,
             3, 2'd1, 3'd3, 15'h0000);
    check(mpr_mode == 1'b0, "R1 R13 MR3 leave", {31'd0, mpr_mode}, 32'd0);
    check(mpr_err == 1'b0, "R13 no error", {31'd0, mpr_err}, 32'd0);

    // R11 second READ while pending
    mrs(3'd3, 15'h0004);
    read_lat = 5'd3;
    run_read("R11 pending burst unchanged", 15'h0000, 3'd0, 3, 8, 0, 2'd0, 1'b1,
             2, 2'd2, 3'd0, 15'h0000);
    check(mpr_err == 1'b1, "R11 rejected read flags error", {31'd0, mpr_err}, 32'd1);

    // R9 DLL not locked
    do_reset();
    mrs(3'd3, 15'h0004);
    dll_locked = 1'b0;
    run_read("R9 no beats without DLL", 15'h0000, 3'd0, 3, 0, 0, 2'd0, 1'b1, 0, 2'd0, 3'd0, 15'd0);
    check(mpr_err == 1'b1, "R9 error without DLL", {31'd0, mpr_err}, 32'd1);
    dll_locked = 1'b1;
    run_read("R12 error stays set", 15'h0000, 3'd0, 3, 8, 0, 2'd0, 1'b1, 0, 2'd0, 3'd0, 15'd0);
    check(mpr_err == 1'b1, "R12 sticky error", {31'd0, mpr_err}, 32'd1);

    // R10 illegal column bits: 8-beat with col[2]=1
    do_reset();
    mrs(3'd3, 15'h0004);
    burst_cfg = 2'd0;
    run_read("R10 8-beat col2 set", 15'h0004, 3'd0, 3, 0, 0, 2'd0, 1'b1, 0, 2'd0, 3'd0, 15'd0);
    check(mpr_err == 1'b1, "R10 error on 8-beat col", {31'd0, mpr_err}, 32'd1);
    // R10 4-beat with col[0]=1
    do_reset();
    mrs(3'd3, 15'h0004);
    burst_cfg = 2'd2;
    run_read("R10 4-beat col0 set", 15'h0001, 3'd0, 3, 0, 0, 2'd0, 1'b1, 0, 2'd0, 3'd0, 15'd0);
    check(mpr_err == 1'b1, "R10 error on 4-beat col", {31'd0, mpr_err}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule